// File: doc/BRIEF.md
# Dual-View Aliased Register File

This block is an eight-entry register file. Each entry is 80 bits wide, and two register views share that one storage array. The wide view serves floating-point code. It reads and writes whole 80-bit entries. The narrow view serves packed-integer SIMD code. It reads the low 64 bits of an entry (the mantissa field). When it writes, it replaces those 64 bits and forces bits 79:64 to all ones, so floating-point logic sees the entry as an infinity/NaN pattern. Each view has two combinational read ports and one write port. Writes take effect on the rising clock edge. A read that addresses an entry being written in the same cycle returns the data being written.

A small ownership state machine tracks which view last claimed the file. It has two states, `ST_FLOAT` and `ST_PACKED`. Transition PK_WRITE moves `ST_FLOAT` to `ST_PACKED` when a packed write is committed. Transition CLEAR moves `ST_PACKED` back to `ST_FLOAT` on the empty-state clear command. The floating-point pipeline raises `fp_busy` while one of its operations holds the file. Any packed read or write attempted in that window raises `conflict`, and a packed write in that window is discarded.

Top module: `alias_regfile`

## Requirements
- R1: A floating-point write (`fp_we`) stores all 80 bits of `fp_wdata` unmodified into entry `fp_waddr`, and a floating-point read port returns the full 80-bit entry.
- R2: A packed read port returns bits 63:0 of the addressed entry.
- R3: A committed packed write replaces bits 63:0 of entry `pk_waddr` with `pk_wdata` and sets bits 79:64 to 16'hFFFF.
- R4: When a read on either view addresses an entry that is written in the same cycle, the read returns the value the entry will hold after the edge.
- R5: When a floating-point write and a committed packed write target the same entry in the same cycle, the floating-point data is stored in full and the packed write has no effect on that entry.
- R6: `conflict` is 1 exactly when `fp_busy` is 1 and either `pk_we` or `pk_re` is 1. A packed write made while `fp_busy` is 1 is not committed: it changes neither the file nor `mode_packed`.
- R7: A committed packed write sets `mode_packed` to 1 (state `ST_PACKED`) from the next cycle, unless `clear` is asserted in the same cycle.
- R8: `clear` sets `mode_packed` to 0 (state `ST_FLOAT`) from the next cycle, and it takes priority over a packed write in the same cycle. Floating-point writes do not change `mode_packed`.
- R9: After reset every entry reads as zero and `mode_packed` is 0.
- R10: The two read ports of each view are independent and may address different entries in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_busy | input | 1 | A floating-point operation holds the file |
| clear | input | 1 | Empty-state clear command, returns ownership to floating point |
| fp_we | input | 1 | Floating-point write enable |
| fp_waddr | input | 3 | Floating-point write index |
| fp_wdata | input | 80 | Floating-point write data |
| fp_raddr0 | input | 3 | Floating-point read port 0 index |
| fp_rdata0 | output | 80 | Floating-point read port 0 data |
| fp_raddr1 | input | 3 | Floating-point read port 1 index |
| fp_rdata1 | output | 80 | Floating-point read port 1 data |
| pk_we | input | 1 | Packed write enable |
| pk_re | input | 1 | Packed read access in progress |
| pk_waddr | input | 3 | Packed write index |
| pk_wdata | input | 64 | Packed write data |
| pk_raddr0 | input | 3 | Packed read port 0 index |
| pk_rdata0 | output | 64 | Packed read port 0 data |
| pk_raddr1 | input | 3 | Packed read port 1 index |
| pk_rdata1 | output | 64 | Packed read port 1 data |
| conflict | output | 1 | Packed access attempted while floating point holds the file |
| mode_packed | output | 1 | Ownership state: 1 = packed view, 0 = floating-point view |

## Verification
The bench interleaves writes from the two views across random indices. It then reads entries through both views, so a missing 16'hFFFF marker or a truncated 80-bit store shows up as a data difference. Random index collisions between writes and same-cycle reads separate correct bypass from stale-array reads. Collisions between the two write ports show whether the priority rule was applied in the right direction. Directed cycles combine `fp_busy` with packed writes, and `clear` with packed writes. These cycles distinguish a blocked write from a committed one, and a clear that wins from one that loses.

// File: rtl/arf_pkg.sv
package arf_pkg;
    typedef enum logic {
        ST_FLOAT  = 1'b0,
        ST_PACKED = 1'b1
    } arf_mode_e;
endpackage

// File: rtl/arf_mode_fsm.sv
module arf_mode_fsm
    import arf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic pk_commit,
    output logic mode_packed
);
    arf_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOAT:  if (pk_commit && !clear) state_d = ST_PACKED;
            ST_PACKED: if (clear)               state_d = ST_FLOAT;
            default:                            state_d = ST_FLOAT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FLOAT;
        else        state_q <= state_d;
    end

    always_comb begin
        mode_packed = (state_q == ST_PACKED);
    end

    p_clear_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !mode_packed);
    p_pack_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_commit && !clear) |=> mode_packed);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!pk_commit && !clear) |=> $stable(mode_packed));
endmodule

// File: rtl/arf_storage.sv
module arf_storage #(
    parameter int NUM_REGS = 8,
    parameter int MANT_W   = 64,
    parameter int MARK_W   = 16,
    localparam int FULL_W  = MANT_W + MARK_W,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             fp_we,
    input  logic [AW-1:0]                    fp_waddr,
    input  logic [FULL_W-1:0]                fp_wdata,
    input  logic                             pk_commit,
    input  logic [AW-1:0]                    pk_waddr,
    input  logic [MANT_W-1:0]                pk_wdata,
    output logic [NUM_REGS-1:0][FULL_W-1:0]  full_view,
    output logic [NUM_REGS-1:0][MANT_W-1:0]  mant_view
);
    localparam logic [MARK_W-1:0] MARKER = '1;

    logic [NUM_REGS-1:0][FULL_W-1:0] ent_q_all;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
        logic [FULL_W-1:0] ent_q, ent_n;

        always_comb begin
            ent_n = ent_q;
            if (pk_commit && pk_waddr == AW'(i)) ent_n = {MARKER, pk_wdata};
            if (fp_we && fp_waddr == AW'(i))     ent_n = fp_wdata;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_n;
        end

        assign full_view[i] = ent_n;
        assign mant_view[i] = ent_n[MANT_W-1:0];
        assign ent_q_all[i] = ent_q;
    end

    p_fp_full_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fp_we |=> ent_q_all[$past(fp_waddr)] == $past(fp_wdata));
    p_pk_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_commit && !(fp_we && fp_waddr == pk_waddr))
        |=> ent_q_all[$past(pk_waddr)] == {MARKER, $past(pk_wdata)});
    p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pk_commit && !fp_we) |=> $stable(ent_q_all));
endmodule

// File: rtl/arf_read_port.sv
module arf_read_port #(
    parameter int NUM_REGS = 8,
    parameter int W        = 80,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0][W-1:0] src,
    input  logic [AW-1:0]              raddr,
    output logic [W-1:0]               rdata
);
    always_comb begin
        rdata = src[raddr];
    end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile #(
    parameter int NUM_REGS = 8,
    parameter int MANT_W   = 64,
    parameter int MARK_W   = 16,
    localparam int FULL_W  = MANT_W + MARK_W,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_busy,
    input  logic              clear,
    input  logic              fp_we,
    input  logic [AW-1:0]     fp_waddr,
    input  logic [FULL_W-1:0] fp_wdata,
    input  logic [AW-1:0]     fp_raddr0,
    output logic [FULL_W-1:0] fp_rdata0,
    input  logic [AW-1:0]     fp_raddr1,
    output logic [FULL_W-1:0] fp_rdata1,
    input  logic              pk_we,
    input  logic              pk_re,
    input  logic [AW-1:0]     pk_waddr,
    input  logic [MANT_W-1:0] pk_wdata,
    input  logic [AW-1:0]     pk_raddr0,
    output logic [MANT_W-1:0] pk_rdata0,
    input  logic [AW-1:0]     pk_raddr1,
    output logic [MANT_W-1:0] pk_rdata1,
    output logic              conflict,
    output logic              mode_packed
);
    logic pk_commit;
    logic [NUM_REGS-1:0][FULL_W-1:0] full_view;
    logic [NUM_REGS-1:0][MANT_W-1:0] mant_view;

    assign conflict  = fp_busy && (pk_we || pk_re);
    assign pk_commit = pk_we && !fp_busy;

    arf_storage #(.NUM_REGS(NUM_REGS), .MANT_W(MANT_W), .MARK_W(MARK_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .fp_we(fp_we), .fp_waddr(fp_waddr), .fp_wdata(fp_wdata),
        .pk_commit(pk_commit), .pk_waddr(pk_waddr), .pk_wdata(pk_wdata),
        .full_view(full_view), .mant_view(mant_view)
    );

    arf_read_port #(.NUM_REGS(NUM_REGS), .W(FULL_W)) u_fp_rd0 (
        .src(full_view), .raddr(fp_raddr0), .rdata(fp_rdata0));
    arf_read_port #(.NUM_REGS(NUM_REGS), .W(FULL_W)) u_fp_rd1 (
        .src(full_view), .raddr(fp_raddr1), .rdata(fp_rdata1));
    arf_read_port #(.NUM_REGS(NUM_REGS), .W(MANT_W)) u_pk_rd0 (
        .src(mant_view), .raddr(pk_raddr0), .rdata(pk_rdata0));
    arf_read_port #(.NUM_REGS(NUM_REGS), .W(MANT_W)) u_pk_rd1 (
        .src(mant_view), .raddr(pk_raddr1), .rdata(pk_rdata1));

    arf_mode_fsm u_mode (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .pk_commit(pk_commit), .mode_packed(mode_packed)
    );

    p_blocked_mode_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pk_we && fp_busy && !clear) |=> $stable(mode_packed));
    p_same_entry_views_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_raddr0 == pk_raddr0) |-> (fp_rdata0[MANT_W-1:0] == pk_rdata0));
endmodule

// File: tb/alias_regfile_test.sv
module alias_regfile_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fp_busy = 0, clear = 0, fp_we = 0, pk_we = 0, pk_re = 0;
    logic [2:0] fp_waddr = 0, fp_raddr0 = 0, fp_raddr1 = 0;
    logic [2:0] pk_waddr = 0, pk_raddr0 = 0, pk_raddr1 = 0;
    logic [79:0] fp_wdata = 0;
    logic [63:0] pk_wdata = 0;
    logic [79:0] fp_rdata0, fp_rdata1;
    logic [63:0] pk_rdata0, pk_rdata1;
    logic conflict, mode_packed;

    int n_cmp = 0, n_bad = 0;
    logic [79:0] m_file [8];
    logic [79:0] m_next [8];
    logic        m_mode = 0;

    always #10 clk = ~clk;

    alias_regfile uut (
        .clk(clk), .rst_n(rst_n), .fp_busy(fp_busy), .clear(clear),
        .fp_we(fp_we), .fp_waddr(fp_waddr), .fp_wdata(fp_wdata),
        .fp_raddr0(fp_raddr0), .fp_rdata0(fp_rdata0),
        .fp_raddr1(fp_raddr1), .fp_rdata1(fp_rdata1),
        .pk_we(pk_we), .pk_re(pk_re), .pk_waddr(pk_waddr), .pk_wdata(pk_wdata),
        .pk_raddr0(pk_raddr0), .pk_rdata0(pk_rdata0),
        .pk_raddr1(pk_raddr1), .pk_rdata1(pk_rdata1),
        .conflict(conflict), .mode_packed(mode_packed)
    );

    task automatic chk(input logic ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [79:0] model_entry(input int i);
        logic [79:0] v = m_file[i];
        if (pk_we && !fp_busy && pk_waddr == 3'(i)) v = {16'hFFFF, pk_wdata};
        if (fp_we && fp_waddr == 3'(i)) v = fp_wdata;
        return v;
    endfunction

    function automatic logic model_mode();
        if (clear) return 1'b0;
        if (pk_we && !fp_busy) return 1'b1;
        return m_mode;
    endfunction

    // inputs already driven; check combinational outputs, clock, check mode
    task automatic cycle(input string tag);
        logic exp_mode;
        logic exp_conf;
        #2;
        for (int i = 0; i < 8; i++) m_next[i] = model_entry(i);
        exp_mode = model_mode();
        exp_conf = fp_busy && (pk_we || pk_re);
        chk(fp_rdata0 == m_next[fp_raddr0], {tag, " R1/R4 fp port0"}, fp_rdata0, m_next[fp_raddr0]);
        chk(fp_rdata1 == m_next[fp_raddr1], {tag, " R10 fp port1"}, fp_rdata1, m_next[fp_raddr1]);
        chk(pk_rdata0 == m_next[pk_raddr0][63:0], {tag, " R2/R4 pk port0"}, {16'h0, pk_rdata0}, {16'h0, m_next[pk_raddr0][63:0]});
        chk(pk_rdata1 == m_next[pk_raddr1][63:0], {tag, " R10 pk port1"}, {16'h0, pk_rdata1}, {16'h0, m_next[pk_raddr1][63:0]});
        chk(conflict == exp_conf, {tag, " R6 conflict"}, {79'h0, conflict}, {79'h0, exp_conf});
        @(posedge clk);
        #1;
        for (int i = 0; i < 8; i++) m_file[i] = m_next[i];
        m_mode = exp_mode;
        chk(mode_packed == m_mode, {tag, " R7/R8 mode"}, {79'h0, mode_packed}, {79'h0, m_mode});
        @(negedge clk);
    endtask

    task automatic idle();
        fp_busy = 0; clear = 0; fp_we = 0; pk_we = 0; pk_re = 0;
    endtask

    initial begin
        #4_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        for (int i = 0; i < 8; i++) m_file[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state
        chk(mode_packed == 1'b0, "R9 mode after reset", {79'h0, mode_packed}, 80'h0);
        for (int i = 0; i < 8; i++) begin
            fp_raddr0 = 3'(i);
            #1 chk(fp_rdata0 == 80'h0, "R9 entry zero", fp_rdata0, 80'h0);
        end

        // R1: full 80-bit float write, then read back
        idle(); fp_we = 1; fp_waddr = 3; fp_wdata = 80'h1234_89AB_CDEF_0123_4567;
        fp_raddr0 = 3; pk_raddr0 = 3; fp_raddr1 = 0; pk_raddr1 = 0;
        cycle("dir-fp-write");
        idle(); cycle("dir-fp-read");

        // R3: packed write forces marker, seen via float port
        idle(); pk_we = 1; pk_waddr = 3; pk_wdata = 64'hDEAD_BEEF_0000_1111;
        fp_raddr1 = 3;
        cycle("dir-pk-write");
        idle(); cycle("dir-pk-marker");
        chk(fp_rdata1[79:64] == 16'hFFFF, "R3 marker bits", {64'h0, fp_rdata1[79:64]}, {64'h0, 16'hFFFF});

        // R8: clear wins over packed write in the same cycle
        idle(); clear = 1; pk_we = 1; pk_waddr = 5; pk_wdata = 64'h5555;
        cycle("dir-clear-vs-pk");
        chk(mode_packed == 1'b0, "R8 clear priority", {79'h0, mode_packed}, 80'h0);

        // R8: float write leaves mode unchanged
        idle(); fp_we = 1; fp_waddr = 6; fp_wdata = 80'h7;
        cycle("dir-fp-no-mode");

        // R6: packed write while float busy is dropped
        idle(); fp_busy = 1; pk_we = 1; pk_waddr = 6; pk_wdata = 64'hFFFF_0000_FFFF_0000;
        fp_raddr0 = 6;
        cycle("dir-conflict-write");
        idle(); cycle("dir-conflict-after");
        chk(fp_rdata0 == 80'h7 && mode_packed == 1'b0, "R6 blocked write", fp_rdata0, 80'h7);

        // R5: simultaneous writes to one entry, float wins
        idle(); fp_we = 1; pk_we = 1; fp_waddr = 2; pk_waddr = 2;
        fp_wdata = 80'h0001_0002_0003_0004_0005; pk_wdata = 64'h9999_9999_9999_9999;
        fp_raddr0 = 2; pk_raddr0 = 2;
        cycle("dir-collide");
        idle(); cycle("dir-collide-after");
        chk(fp_rdata0 == 80'h0001_0002_0003_0004_0005, "R5 float priority", fp_rdata0, 80'h0001_0002_0003_0004_0005);

        // random traffic
        for (int n = 0; n < 400; n++) begin
            fp_busy   = ($urandom_range(0, 3) == 0);
            clear     = ($urandom_range(0, 9) == 0);
            fp_we     = ($urandom_range(0, 2) == 0);
            pk_we     = ($urandom_range(0, 1) == 0);
            pk_re     = ($urandom_range(0, 1) == 0);
            fp_waddr  = 3'($urandom_range(0, 7));
            pk_waddr  = 3'($urandom_range(0, 7));
            fp_raddr0 = 3'($urandom_range(0, 7));
            fp_raddr1 = 3'($urandom_range(0, 7));
            pk_raddr0 = 3'($urandom_range(0, 7));
            pk_raddr1 = 3'($urandom_range(0, 7));
            fp_wdata  = {16'($urandom), $urandom, $urandom};
            pk_wdata  = {$urandom, $urandom};
            cycle("random");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule